// File: doc/BRIEF.md
# Security-Banked System Control Register

This block holds the system control word of a processor's control coprocessor in two copies: one for the Secure world and one for the Non-secure world. Reads and writes arrive as single-cycle strobes. Each strobe carries the security state and the privilege level of the instruction that issued it. The block decides which copy the access targets and checks whether the access is allowed. When it is not allowed, the block raises an undefined-instruction indication in the same cycle as the strobe.

The block sends the six defined enable bits of the currently active copy to the core. These are: MMU enable, strict alignment checking, data caching, flow prediction, instruction caching, and high vectors. The active copy is chosen by the core's present security state, registered once. The block also forms the exception vector base. When the active high-vector bit is set, the base is the fixed high address. Otherwise it is the vector base register value of the active world, which arrives on an input.

The access strobe is accepted in every cycle and there is no back-pressure. The requester never waits. A read returns its data in the same cycle as its strobe. A write becomes visible from the next clock edge onward.

Top module: `sys_ctrl_bank`

## Requirements
- R1: Reset is synchronous and active-low. During reset both copies load the same value: all defined bits 0 except the high-vector bit (bit 13), which takes `vinit_hi`. Each copy therefore reads 0x00000078, or 0x00002078 when `vinit_hi` was 1. Later changes of `vinit_hi` have no effect.
- R2: The writable bits are bit 0 (MMU enable), bit 1 (alignment check), bit 2 (data cache), bit 11 (flow prediction), bit 12 (instruction cache) and bit 13 (high vectors). All are active-high, and each drives the matching `ctl_*` output.
- R3: Read data has bits 6:3 always 1, and bits 10:7 and 31:14 always 0, whatever was written.
- R4: Any strobe with `acc_priv`=0 raises `acc_undef` in that cycle, returns `acc_rdata`=0 and changes neither copy.
- R5: A write with `acc_ns`=0, `acc_priv`=1 and `wr_lock`=1 raises `acc_undef` and leaves the Secure copy unchanged. A Secure privileged read under lock is still served without `acc_undef`.
- R6: A privileged access with `acc_ns`=0 reads or writes the Secure copy. One with `acc_ns`=1 reads or writes the Non-secure copy. The other copy is untouched.
- R7: The `ctl_*` outputs show the copy selected by the value `cur_ns` had at the previous clock edge (1 = Non-secure).
- R8: `vec_base` is 0xFFFF0000 when the active copy's bit 13 is 1. Otherwise it equals `vbar_ns` if the Non-secure copy is active and `vbar_s` if the Secure copy is active.
- R9: With no strobe, `acc_undef` is 0 and `acc_rdata` is 0. A write strobe also returns `acc_rdata`=0.
- R10: An allowed write is seen by a read in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vinit_hi | input | 1 | Reset value of the high-vector bit |
| wr_lock | input | 1 | Blocks Secure writes when 1 |
| cur_ns | input | 1 | Core's present security state (1 = Non-secure) |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ns | input | 1 | Security state of the access |
| acc_priv | input | 1 | Privilege of the access (1 = privileged) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle as the strobe |
| acc_undef | output | 1 | Undefined-instruction pulse |
| vbar_s | input | 32 | Secure vector base register value |
| vbar_ns | input | 32 | Non-secure vector base register value |
| ctl_mmu | output | 1 | MMU enable |
| ctl_align | output | 1 | Strict alignment checking |
| ctl_dcache | output | 1 | Data caching enable |
| ctl_flowpred | output | 1 | Flow prediction enable |
| ctl_icache | output | 1 | Instruction caching enable |
| ctl_hivec | output | 1 | High vectors selected |
| vec_base | output | 32 | Exception vector base |

## Verification
The bench tests the lock on both directions. A design that gated reads as well as writes would flag Secure reads under lock, and one that ignored the lock would change the Secure copy. It writes one copy and then reads the other, which catches crossed bank selection or a shared register. It toggles `cur_ns` and samples the controls in the same cycle and in the next one, which exposes a selection that is not registered or is delayed too long. It also writes all ones and all zeros to expose reserved bits that leak, and it repeats reset with both values of `vinit_hi` to catch a reset value that is stuck.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned POS_M = 0;
  localparam int unsigned POS_A = 1;
  localparam int unsigned POS_C = 2;
  localparam int unsigned POS_Z = 11;
  localparam int unsigned POS_I = 12;
  localparam int unsigned POS_V = 13;
  localparam int unsigned RAO_LO = 3;
  localparam int unsigned RAO_HI = 6;

  localparam logic [DW-1:0] HI_VEC_BASE = 32'hFFFF_0000;

  typedef struct packed {
    logic v;
    logic i;
    logic z;
    logic c;
    logic a;
    logic m;
  } sctl_bits_t;

  function automatic logic [DW-1:0] sctl_pack(input sctl_bits_t b);
    logic [DW-1:0] w;
    w = '0;
    w[RAO_HI:RAO_LO] = '1;
    w[POS_V] = b.v;
    w[POS_I] = b.i;
    w[POS_Z] = b.z;
    w[POS_C] = b.c;
    w[POS_A] = b.a;
    w[POS_M] = b.m;
    return w;
  endfunction

  function automatic sctl_bits_t sctl_unpack(input logic [DW-1:0] w);
    sctl_bits_t b;
    b.v = w[POS_V];
    b.i = w[POS_I];
    b.z = w[POS_Z];
    b.c = w[POS_C];
    b.a = w[POS_A];
    b.m = w[POS_M];
    return b;
  endfunction
endpackage

// File: rtl/sctl_perm.sv
module sctl_perm (
  input  logic valid,
  input  logic write,
  input  logic ns,
  input  logic priv,
  input  logic lock,
  output logic wr_s,
  output logic wr_ns,
  output logic rd_ok,
  output logic undef
);
  logic user_fault;
  logic lock_fault;

  always_comb begin
    user_fault = valid & ~priv;
    lock_fault = valid & priv & write & ~ns & lock;
    undef      = user_fault | lock_fault;
    wr_s       = valid & priv & write & ~ns & ~lock;
    wr_ns      = valid & priv & write & ns;
    rd_ok      = valid & priv & ~write;
  end
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vinit,
  input  logic       we,
  input  sctl_bits_t wbits,
  output sctl_bits_t bits
);
  sctl_bits_t bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q   <= '0;
      bits_q.v <= vinit;
    end else if (we) begin
      bits_q <= wbits;
    end
  end

  assign bits = bits_q;
endmodule

// File: rtl/sctl_vecsel.sv
module sctl_vecsel #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] HI_BASE = '1
) (
  input  logic          hivec,
  input  logic          sel_ns,
  input  logic [AW-1:0] base_s,
  input  logic [AW-1:0] base_ns,
  output logic [AW-1:0] base
);
  logic [AW-1:0] low_base;

  always_comb begin
    low_base = sel_ns ? base_ns : base_s;
    base     = hivec ? HI_BASE : low_base;
  end
endmodule

// File: rtl/sys_ctrl_bank.sv
module sys_ctrl_bank
  import sctl_pkg::*;
#(
  parameter int unsigned NBANK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vinit_hi,
  input  logic          wr_lock,
  input  logic          cur_ns,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_ns,
  input  logic          acc_priv,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          acc_undef,
  input  logic [DW-1:0] vbar_s,
  input  logic [DW-1:0] vbar_ns,
  output logic          ctl_mmu,
  output logic          ctl_align,
  output logic          ctl_dcache,
  output logic          ctl_flowpred,
  output logic          ctl_icache,
  output logic          ctl_hivec,
  output logic [DW-1:0] vec_base
);
  localparam int unsigned SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic       wr_s, wr_ns, rd_ok;
  logic [NBANK-1:0] bank_we;
  sctl_bits_t bank_bits [NBANK];
  sctl_bits_t wbits;
  sctl_bits_t act_bits;
  logic       sel_q;
  logic [DW-1:0] word_s, word_ns;
  logic       unused_wdata;

  sctl_perm u_perm (
    .valid (acc_valid),
    .write (acc_write),
    .ns    (acc_ns),
    .priv  (acc_priv),
    .lock  (wr_lock),
    .wr_s  (wr_s),
    .wr_ns (wr_ns),
    .rd_ok (rd_ok),
    .undef (acc_undef)
  );

  assign wbits        = sctl_unpack(acc_wdata);
  assign unused_wdata = ^{acc_wdata[DW-1:POS_V+1], acc_wdata[POS_Z-1:POS_C+1]};
  assign bank_we      = {wr_ns, wr_s};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sctl_bank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .vinit (vinit_hi),
      .we    (bank_we[b]),
      .wbits (wbits),
      .bits  (bank_bits[b])
    );
  end

  assign word_s  = sctl_pack(bank_bits[0]);
  assign word_ns = sctl_pack(bank_bits[1]);

  always_comb begin
    acc_rdata = '0;
    if (rd_ok) acc_rdata = acc_ns ? word_ns : word_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= cur_ns;
  end

  logic [SEL_W-1:0] sel_idx;
  assign sel_idx  = SEL_W'(sel_q);
  assign act_bits = bank_bits[sel_idx];

  assign ctl_mmu      = act_bits.m;
  assign ctl_align    = act_bits.a;
  assign ctl_dcache   = act_bits.c;
  assign ctl_flowpred = act_bits.z;
  assign ctl_icache   = act_bits.i;
  assign ctl_hivec    = act_bits.v;

  sctl_vecsel #(
    .AW      (DW),
    .HI_BASE (HI_VEC_BASE)
  ) u_vec (
    .hivec   (act_bits.v),
    .sel_ns  (sel_q),
    .base_s  (vbar_s),
    .base_ns (vbar_ns),
    .base    (vec_base)
  );
endmodule

// File: rtl/sys_ctrl_bank_chk.sv
module sys_ctrl_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_lock,
  input logic        cur_ns,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        acc_ns,
  input logic        acc_priv,
  input logic [31:0] acc_rdata,
  input logic        acc_undef,
  input logic        ctl_hivec,
  input logic [31:0] vec_base,
  input logic [31:0] word_s,
  input logic [31:0] word_ns
);
  // R4
  user_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_priv) |-> (acc_undef && acc_rdata == 32'h0));

  // R4
  user_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_priv) |=> ($stable(word_s) && $stable(word_ns)));

  // R5
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_priv && acc_write && !acc_ns && wr_lock) |=> $stable(word_s));

  // R6
  ns_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_priv && acc_write && acc_ns) |=> $stable(word_s));

  // R3
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_priv && !acc_write) |-> (acc_rdata[10:3] == 8'h0F && acc_rdata[31:14] == '0));

  // R8
  hivec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hivec |-> (vec_base == 32'hFFFF_0000));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_undef && acc_rdata == 32'h0));

  // R7
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n)) |-> (ctl_hivec == ($past(cur_ns) ? word_ns[13] : word_s[13])));
endmodule

bind sys_ctrl_bank sys_ctrl_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_lock   (wr_lock),
  .cur_ns    (cur_ns),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_ns    (acc_ns),
  .acc_priv  (acc_priv),
  .acc_rdata (acc_rdata),
  .acc_undef (acc_undef),
  .ctl_hivec (ctl_hivec),
  .vec_base  (vec_base),
  .word_s    (word_s),
  .word_ns   (word_ns)
);

// File: tb/sys_ctrl_bank_bench.sv
module sys_ctrl_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vinit_hi = 1'b0;
  logic        wr_lock = 1'b0;
  logic        cur_ns = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_ns = 1'b0;
  logic        acc_priv = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_undef;
  logic [31:0] vbar_s = '0;
  logic [31:0] vbar_ns = '0;
  logic        ctl_mmu, ctl_align, ctl_dcache, ctl_flowpred, ctl_icache, ctl_hivec;
  logic [31:0] vec_base;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] mdl_s, mdl_ns;
  logic        mdl_sel;

  always #5 clk = ~clk;

  sys_ctrl_bank u_sys_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .vinit_hi(vinit_hi), .wr_lock(wr_lock), .cur_ns(cur_ns),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_ns(acc_ns), .acc_priv(acc_priv),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_undef(acc_undef),
    .vbar_s(vbar_s), .vbar_ns(vbar_ns),
    .ctl_mmu(ctl_mmu), .ctl_align(ctl_align), .ctl_dcache(ctl_dcache),
    .ctl_flowpred(ctl_flowpred), .ctl_icache(ctl_icache), .ctl_hivec(ctl_hivec),
    .vec_base(vec_base)
  );

  function automatic logic [31:0] fold(input logic [31:0] w);
    return (w & 32'h0000_3807) | 32'h0000_0078;
  endfunction

  function automatic logic [5:0] ctl_of(input logic [31:0] w);
    return {w[13], w[12], w[11], w[2], w[1], w[0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic vi);
    @(negedge clk);
    rst_n = 1'b0; vinit_hi = vi; cur_ns = 1'b0; acc_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    vinit_hi = ~vi;
    mdl_s = 32'h78 | (32'(vi) << 13);
    mdl_ns = mdl_s;
    mdl_sel = 1'b0;
  endtask

  task automatic step(input logic v, input logic w, input logic ns, input logic pv,
                      input logic lk, input logic cns, input logic [31:0] wd, input string tag);
    logic        e_undef;
    logic [31:0] e_rd, act;
    string       t;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_ns = ns; acc_priv = pv;
    wr_lock = lk; cur_ns = cns; acc_wdata = wd;
    vbar_s = $urandom; vbar_ns = $urandom;
    #1;
    e_undef = v & (!pv | (w & !ns & lk));
    e_rd = (v & !w & pv) ? (ns ? mdl_ns : mdl_s) : 32'h0;
    if (tag != "") t = tag;
    else if (!v) t = "R9";
    else if (!pv) t = "R4";
    else if (w && !ns && lk) t = "R5";
    else t = "R6";
    chk(t, "undef", 32'(acc_undef), 32'(e_undef));
    chk(t, "rdata", acc_rdata, e_rd);
    if (v && !w && pv)
      chk("R3", "reserved", acc_rdata & 32'hFFFF_C7F8, 32'h0000_0078);
    act = mdl_sel ? mdl_ns : mdl_s;
    chk("R2 R7", "ctl", 32'({ctl_hivec, ctl_icache, ctl_flowpred, ctl_dcache, ctl_align, ctl_mmu}),
        32'(ctl_of(act)));
    chk("R8", "vec_base", vec_base, act[13] ? 32'hFFFF_0000 : (mdl_sel ? vbar_ns : vbar_s));
    @(posedge clk);
    if (v && w && pv) begin
      if (ns) mdl_ns = fold(wd);
      else if (!lk) mdl_s = fold(wd);
    end
    mdl_sel = cns;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset with high vectors requested
    do_reset(1'b1);
    step(1, 0, 0, 1, 0, 0, 0, "R1");
    step(1, 0, 1, 1, 0, 0, 0, "R1");
    // R2 R10: write all ones to Secure, read back next cycle
    step(1, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, "R2");
    step(1, 0, 0, 1, 0, 0, 0, "R10");
    // R6: Non-secure copy untouched by the Secure write
    step(1, 0, 1, 1, 0, 0, 0, "R6");
    // R6 R10: write zeros to Non-secure, read both
    step(1, 1, 1, 1, 0, 0, 32'h0000_0000, "R6");
    step(1, 0, 1, 1, 0, 0, 0, "R10");
    step(1, 0, 0, 1, 0, 0, 0, "R6");
    // R7: switch core state; controls follow one cycle later
    step(0, 0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    // R5: locked Secure write refused, locked Secure read served
    step(1, 1, 0, 1, 1, 0, 32'h0000_0000, "R5");
    step(1, 0, 0, 1, 1, 0, 0, "R5");
    // R4: user accesses both worlds
    step(1, 1, 0, 0, 0, 0, 32'h0, "R4");
    step(1, 1, 1, 0, 0, 0, 32'hFFFF_FFFF, "R4");
    step(1, 0, 1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 1, 0, 0, 0, "R4");
    step(1, 0, 1, 1, 0, 0, 0, "R4");
    // R1: second reset without high vectors
    do_reset(1'b0);
    step(1, 0, 0, 1, 0, 0, 0, "R1");
    step(1, 0, 1, 1, 0, 1, 0, "R1");
    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic v, w, ns, pv, lk, cns;
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      ns = $urandom % 2;
      pv = ($urandom % 4) != 0;
      lk = ($urandom % 10) < 3;
      cns = ($urandom % 8) == 0 ? ~cur_ns : cur_ns;
      step(v, w, ns, pv, lk, cns, $urandom, "");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule